// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Repeat Masks

This block holds four byte-wide alarm registers (seconds, minutes, hours, date) and compares them against a running BCD time of day. The comparison happens on each one-second tick strobe. On a match it raises a one-cycle interrupt pulse.

Bit 7 of every alarm register is a mask bit. The pattern of the four mask bits sets the repeat rate:

| Masked fields | Repeat rate |
|---|---|
| none | monthly |
| date only | daily |
| date and hours | hourly |
| date, hours and minutes | every minute |
| any other pattern | every second |

Writes are checked field by field. A write whose BCD field is out of range is dropped, and the register keeps its old value.

Software programs the registers through a simple write port and reads them back through a registered read port. The time source drives the time bus and the tick. Generating the time is done elsewhere.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, all four alarm registers read as 0x00 and `alarm_irq` is low.
- R2: Register addresses are 0 = seconds, 1 = minutes, 2 = hours, 3 = date. An accepted write stores the full byte. `rd_data` shows the register selected by `rd_addr` one clock after `rd_addr` is applied.
- R3: A seconds or minutes write is accepted only when bits 6:0, read as BCD, hold 0 to 59 with a units digit no greater than 9. Otherwise the register is unchanged.
- R4: An hours write is accepted only when bits 5:0, read as BCD, hold 0 to 23 with a units digit no greater than 9. Otherwise the register is unchanged.
- R5: A date write is accepted only when bits 5:0 are nonzero and the units digit is no greater than 9. Otherwise the register is unchanged.
- R6: With no mask bit set, a tick fires the alarm only when date (bits 5:0), hours (bits 5:0), minutes (bits 6:0) and seconds (bits 6:0) all equal the time bus.
- R7: With only the date mask set, the date field is ignored and hours, minutes and seconds must match.
- R8: With the date and hours masks set, only minutes and seconds must match.
- R9: With the date, hours and minutes masks set, only seconds must match.
- R10: With any other mask pattern, every tick fires the alarm.
- R11: `alarm_irq` is high only in the single cycle after a firing tick, and never without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 8 | Registered read byte |
| tod_sec | input | 8 | Current seconds, BCD |
| tod_min | input | 8 | Current minutes, BCD |
| tod_hour | input | 8 | Current hours, BCD |
| tod_date | input | 8 | Current date, BCD |
| tick | input | 1 | One-second strobe, one cycle wide |
| alarm_irq | output | 1 | Alarm interrupt pulse |

## Verification
The assertions assume that `tick` is low while reset is held. They also assume that the time bus is stable in every cycle where `tick` is high.

The bench drives all inputs on the falling clock edge. Each tick lasts exactly one cycle, and consecutive ticks are kept at least two cycles apart. The time bus is always settled before the tick that samples it.

Because of that spacing, every interrupt pulse is separated from the next one, and the single-cycle pulse shape can be observed directly.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NFIELD = 4;
  localparam int DW     = 8;

  typedef enum logic [1:0] {
    K_SEC  = 2'd0,
    K_MIN  = 2'd1,
    K_HOUR = 2'd2,
    K_DATE = 2'd3
  } field_kind_e;

  // Bits of a byte that take part in legality checks and comparison
  function automatic logic [6:0] field_bits(field_kind_e k, logic [7:0] v);
    if (k == K_SEC || k == K_MIN) return v[6:0];
    return {1'b0, v[5:0]};
  endfunction

  function automatic logic value_legal(field_kind_e k, logic [7:0] v);
    logic [3:0] units;
    logic [2:0] tens;
    units = v[3:0];
    case (k)
      K_SEC, K_MIN: begin
        tens = v[6:4];
        return (units <= 4'd9) && (tens <= 3'd5);
      end
      K_HOUR: begin
        tens = {1'b0, v[5:4]};
        return (units <= 4'd9) &&
               ((tens < 3'd2) || ((tens == 3'd2) && (units <= 4'd3)));
      end
      default: begin
        return (units <= 4'd9) && (v[5:0] != 6'd0);
      end
    endcase
  endfunction
endpackage

// File: rtl/alarm_field_reg.sv
module alarm_field_reg
  import alarm_pkg::*;
#(
  parameter field_kind_e KIND = K_SEC,
  parameter int          IDX  = 0,
  parameter int          AW   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] tod,
  output logic [DW-1:0] value,
  output logic          masked,
  output logic          eq
);
  logic sel;
  logic legal;
  logic unused_tod_top;

  assign sel    = wr_en && (wr_addr == AW'(IDX));
  assign legal  = value_legal(KIND, wr_data);
  assign masked = value[DW-1];
  assign eq     = (field_bits(KIND, value) == field_bits(KIND, tod));
  assign unused_tod_top = ^tod[7:6];

  always_ff @(posedge clk) begin
    if (rst)                value <= '0;
    else if (sel && legal)  value <= wr_data;
  end

  // Covers R3, R4 and R5 for the field this instance holds
  p_reject_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (sel && !legal) |=> $stable(value));

  p_accept_store_r2: assert property (@(posedge clk) disable iff (rst)
    (sel && legal) |=> (value == $past(wr_data)));
endmodule

// File: rtl/alarm_rate_decode.sv
module alarm_rate_decode
  import alarm_pkg::*;
(
  input  logic [NFIELD-1:0] mask,     // [0]=sec [1]=min [2]=hour [3]=date
  output logic [NFIELD-1:0] cmp_en
);
  always_comb begin
    case (mask)
      4'b0000: cmp_en = 4'b1111;  // monthly
      4'b1000: cmp_en = 4'b0111;  // daily
      4'b1100: cmp_en = 4'b0011;  // hourly
      4'b1110: cmp_en = 4'b0001;  // every minute
      default: cmp_en = 4'b0000;  // every second
    endcase
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [NFIELD-1:0] cmp_en,
  input  logic [NFIELD-1:0] eq,
  output logic              irq
);
  logic hit;

  always_comb begin
    hit = 1'b1;
    for (int i = 0; i < NFIELD; i++)
      if (cmp_en[i] && !eq[i]) hit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= tick && hit;
  end

  p_irq_needs_tick_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(tick));

  p_every_tick_r10: assert property (@(posedge clk) disable iff (rst)
    (tick && (cmp_en == '0)) |=> irq);

  p_monthly_mismatch_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && (&cmp_en) && !(&eq)) |=> !irq);

  p_second_field_r9: assert property (@(posedge clk) disable iff (rst)
    (tick && cmp_en[0] && !eq[0]) |=> !irq);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import alarm_pkg::*;
#(
  parameter int AW = $clog2(NFIELD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] tod_sec,
  input  logic [DW-1:0] tod_min,
  input  logic [DW-1:0] tod_hour,
  input  logic [DW-1:0] tod_date,
  input  logic          tick,
  output logic          alarm_irq
);
  logic [NFIELD-1:0][DW-1:0] tod_vec;
  logic [NFIELD-1:0][DW-1:0] regs;
  logic [NFIELD-1:0]         mask;
  logic [NFIELD-1:0]         eq;
  logic [NFIELD-1:0]         cmp_en;

  assign tod_vec = {tod_date, tod_hour, tod_min, tod_sec};

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    alarm_field_reg #(
      .KIND (field_kind_e'(g)),
      .IDX  (g),
      .AW   (AW)
    ) u_reg (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .tod     (tod_vec[g]),
      .value   (regs[g]),
      .masked  (mask[g]),
      .eq      (eq[g])
    );
  end

  alarm_rate_decode u_dec (
    .mask   (mask),
    .cmp_en (cmp_en)
  );

  alarm_match u_match (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .cmp_en (cmp_en),
    .eq     (eq),
    .irq    (alarm_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= regs[rd_addr];
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!alarm_irq && (rd_data == '0)));
endmodule

// File: tb/tb_rtc_alarm_match.sv
module tb_rtc_alarm_match;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [7:0] tod_sec = '0, tod_min = '0, tod_hour = '0, tod_date = '0;
  logic       tick = 1'b0;
  logic       alarm_irq;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  rtc_alarm_match dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tod_sec(tod_sec), .tod_min(tod_min),
    .tod_hour(tod_hour), .tod_date(tod_date), .tick(tick), .alarm_irq(alarm_irq)
  );

  // {accept, addr[1:0], data[7:0]}
  localparam int NV = 18;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h59}, {1'b0, 2'd0, 8'h60}, {1'b0, 2'd0, 8'h5A},
    {1'b1, 2'd0, 8'hB0}, {1'b0, 2'd0, 8'hFF},
    {1'b1, 2'd1, 8'h00}, {1'b1, 2'd1, 8'h45}, {1'b0, 2'd1, 8'h75},
    {1'b1, 2'd2, 8'h23}, {1'b0, 2'd2, 8'h24}, {1'b1, 2'd2, 8'h19},
    {1'b0, 2'd2, 8'h30}, {1'b0, 2'd2, 8'h1A}, {1'b1, 2'd2, 8'hC5},
    {1'b0, 2'd3, 8'h00}, {1'b1, 2'd3, 8'h31}, {1'b0, 2'd3, 8'h80},
    {1'b0, 2'd3, 8'h0B}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_addr = a;
    @(negedge clk); check(rd_data, exp, tag);
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m,
                          input logic [7:0] h, input logic [7:0] d);
    @(negedge clk); tod_sec = s; tod_min = m; tod_hour = h; tod_date = d;
  endtask

  // Tick for one cycle, expect the pulse one clock later, then low again
  task automatic tick_chk(input logic exp, input string tag);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check({7'd0, alarm_irq}, {7'd0, exp}, tag);
    @(negedge clk);
    check({7'd0, alarm_irq}, 8'd0, {tag, " R11 pulse end"});
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] shadow [4];
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int i = 0; i < 4; i++) rd_chk(2'(i), 8'h00, "R1 reset reg");
    check({7'd0, alarm_irq}, 8'd0, "R1 reset irq");

    // R2..R5 write validation walked from the table
    for (int i = 0; i < 4; i++) shadow[i] = 8'h00;
    for (int i = 0; i < NV; i++) begin
      logic [1:0] a;
      a = VEC[i][9:8];
      wr(a, VEC[i][7:0]);
      if (VEC[i][10]) shadow[a] = VEC[i][7:0];
      case (a)
        2'd0, 2'd1: rd_chk(a, shadow[a], "R3 sec/min write");
        2'd2:       rd_chk(a, shadow[a], "R4 hour write");
        default:    rd_chk(a, shadow[a], "R5 date write");
      endcase
    end
    rd_chk(2'd2, 8'hC5, "R2 full byte kept");

    // R1 reset again clears programmed registers
    do_reset();
    rd_chk(2'd3, 8'h00, "R1 reset clears date");
    rd_chk(2'd0, 8'h00, "R1 reset clears sec");

    // R6 monthly
    wr(2'd0, 8'h30); wr(2'd1, 8'h15); wr(2'd2, 8'h12); wr(2'd3, 8'h07);
    set_time(8'h30, 8'h15, 8'h12, 8'h07);
    tick_chk(1'b1, "R6 monthly all match");
    set_time(8'h30, 8'h15, 8'h12, 8'h08);
    tick_chk(1'b0, "R6 monthly date differs");
    set_time(8'h31, 8'h15, 8'h12, 8'h07);
    tick_chk(1'b0, "R6 monthly sec differs");

    // R11 match held but no tick
    set_time(8'h30, 8'h15, 8'h12, 8'h07);
    repeat (3) @(negedge clk);
    check({7'd0, alarm_irq}, 8'd0, "R11 no tick no irq");

    // R7 daily
    wr(2'd3, 8'h87);
    set_time(8'h30, 8'h15, 8'h12, 8'h09);
    tick_chk(1'b1, "R7 daily date ignored");
    set_time(8'h30, 8'h16, 8'h12, 8'h09);
    tick_chk(1'b0, "R7 daily min differs");

    // R8 hourly
    wr(2'd2, 8'h92);
    set_time(8'h30, 8'h15, 8'h05, 8'h09);
    tick_chk(1'b1, "R8 hourly hour ignored");
    set_time(8'h31, 8'h15, 8'h05, 8'h09);
    tick_chk(1'b0, "R8 hourly sec differs");

    // R9 every minute
    wr(2'd1, 8'h95);
    set_time(8'h30, 8'h40, 8'h05, 8'h09);
    tick_chk(1'b1, "R9 minute min ignored");
    set_time(8'h29, 8'h40, 8'h05, 8'h09);
    tick_chk(1'b0, "R9 minute sec differs");

    // R10 all masked
    wr(2'd0, 8'hB0);
    set_time(8'h01, 8'h02, 8'h03, 8'h04);
    tick_chk(1'b1, "R10 all masked");

    // R10 odd pattern: seconds mask only
    do_reset();
    wr(2'd0, 8'h80); wr(2'd3, 8'h01);
    set_time(8'h11, 8'h22, 8'h10, 8'h20);
    tick_chk(1'b1, "R10 sec mask only");
    tick_chk(1'b1, "R10 sec mask only again");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule